// File: doc/BRIEF.md
# Byte/Word Integer Adder-Subtractor with Status Word

This block performs the six integer arithmetic steps of a small processor datapath: add, add with carry, subtract, subtract with borrow, increment and decrement. It works on 8-bit or 16-bit operands, chosen by a size select. The arithmetic result is combinational and is ready in the same cycle as the operands.

Each operation produces six status conditions. These are carry (or borrow), half-carry across the low nibble, signed overflow, parity, sign and zero. They are packed into a 16-bit status word at fixed bit positions. The status word is held in a register that loads on a clock edge when the write input is high. The stored carry is fed back as the extra one for the carry-using add and the borrow-using subtract. Increment and decrement update every condition except the stored carry, so a multi-word count does not disturb a carry chain that is in progress.

Top module: `arith_flag_unit`

## Requirements
- R1: Op code 0 (ADD) returns a+b and op code 1 (ADC) returns a+b+C, where C is status bit 0. In both, status bit 0 becomes the carry out of the top bit of the selected width.
- R2: Op code 2 (SUB) returns a-b and op code 3 (SBB) returns a-b-C. In both, status bit 0 is set exactly when a borrow into the top bit is needed, that is, when the unsigned difference is negative.
- R3: Status bit 11 (overflow) is set exactly when the true signed result of the operation lies outside the signed range of the selected width.
- R4: Status bit 4 (half-carry) is set on a carry out of bit 3 for additions, and on a borrow into bit 4 for subtractions.
- R5: Status bit 7 equals the result's top bit for the selected width. Status bit 6 is set when the result is zero. Status bit 2 is set when the low 8 bits of the result hold an even number of ones, in both widths.
- R6: Op code 4 (INC) returns a+1 and op code 5 (DEC) returns a-1. Both ignore operand b, leave status bit 0 at its stored value and update bits 2, 4, 6, 7 and 11.
- R7: In the status word, bits 0, 2, 4, 6, 7 and 11 are the only bits that can be set. Every other bit reads zero.
- R8: When word_mode is 0, only the low 8 bits of each operand are used and result[15:8] is zero. When word_mode is 1, all 16 bits are used.
- R9: The status register loads the new status word on a rising clock edge only when wr_en is 1. Otherwise it holds its value.
- R10: An asserted rst_n clears the status word to zero at once, and the word stays zero until a write after reset release.
- R11: Op codes 6 and 7 are reserved. They give a zero result and leave the status word unchanged even when wr_en is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a | input | 16 | First operand (minuend for subtraction) |
| op_b | input | 16 | Second operand (ignored by increment and decrement) |
| op_code | input | 3 | Operation select, encoded as in R1, R2, R6 and R11 |
| word_mode | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| wr_en | input | 1 | Loads the status register on the next clock edge |
| result | output | 16 | Combinational arithmetic result |
| flags | output | 16 | Registered status word |

## Verification
The bench builds the block with its defaults: a 16-bit word lane, an 8-bit byte lane and a 4-bit nibble boundary. At the byte width, every value of the first operand is swept against sixteen spread values of the second operand. Each combination runs under every operation and with the stored carry both clear and set. This covers all carry, borrow, half-carry, overflow and parity boundaries of the narrow lane, and the byte sweep keeps nonzero upper operand bits to show they are ignored. The wide lane is driven at its edges: wrap of all ones, the largest positive value plus one, two negative values summing past range, and decrement of zero. Blocked writes, reserved codes and a mid-run reset are also checked.

// File: rtl/afu_pkg.sv
package afu_pkg;

  localparam int FLAG_W = 16;

  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int OF_POS = 11;

  localparam logic [FLAG_W-1:0] FLAG_MASK =
    FLAG_W'((1 << CF_POS) | (1 << PF_POS) | (1 << AF_POS) |
            (1 << ZF_POS) | (1 << SF_POS) | (1 << OF_POS));

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } afu_op_e;

  typedef struct packed {
    logic sub;
    logic use_cin;
    logic force_one;
    logic keep_cy;
    logic valid;
  } afu_ctl_t;

endpackage

// File: rtl/afu_rst_sync.sv
module afu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/afu_decode.sv
module afu_decode
  import afu_pkg::*;
(
  input  logic [2:0] op_code,
  output afu_ctl_t   ctl
);

  always_comb begin
    ctl = '0;
    unique case (afu_op_e'(op_code))
      OP_ADD: begin ctl.valid = 1'b1; end
      OP_ADC: begin ctl.valid = 1'b1; ctl.use_cin = 1'b1; end
      OP_SUB: begin ctl.valid = 1'b1; ctl.sub = 1'b1; end
      OP_SBB: begin ctl.valid = 1'b1; ctl.sub = 1'b1; ctl.use_cin = 1'b1; end
      OP_INC: begin ctl.valid = 1'b1; ctl.force_one = 1'b1; ctl.keep_cy = 1'b1; end
      OP_DEC: begin
        ctl.valid     = 1'b1;
        ctl.sub       = 1'b1;
        ctl.force_one = 1'b1;
        ctl.keep_cy   = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/afu_lane.sv
module afu_lane #(
  parameter int W     = 8,
  parameter int NIB_W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         ac,
  output logic         ov
);

  logic [W-1:0]   bx;
  logic           c0;
  logic [W:0]     sum;
  logic [NIB_W:0] nsum;

  always_comb begin
    bx   = sub ? ~b : b;
    c0   = sub ^ cin;
    sum  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, c0};
    nsum = {1'b0, a[NIB_W-1:0]} + {1'b0, bx[NIB_W-1:0]} + {{NIB_W{1'b0}}, c0};
    res  = sum[W-1:0];
    cy   = sum[W] ^ sub;
    ac   = nsum[NIB_W] ^ sub;
    ov   = (a[W-1] == bx[W-1]) && (res[W-1] != a[W-1]);
  end

  always_comb begin
    if (!sub && !cin && (a == '0)) begin
      AST_ADD_ZERO_IDENTITY: assert (res == b && !cy && !ov); // R1
    end
  end

endmodule

// File: rtl/afu_flag_pack.sv
module afu_flag_pack
  import afu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] res,
  input  logic              word_mode,
  input  logic              cy,
  input  logic              ac,
  input  logic              ov,
  input  logic              keep_cy,
  input  logic              old_cy,
  output logic [FLAG_W-1:0] flag_word
);

  logic sgn;
  logic zro;
  logic par;

  always_comb begin
    sgn = word_mode ? res[DATA_W-1] : res[BYTE_W-1];
    zro = (res == '0);
    par = ~^res[BYTE_W-1:0];
    flag_word         = '0;
    flag_word[CF_POS] = keep_cy ? old_cy : cy;
    flag_word[PF_POS] = par;
    flag_word[AF_POS] = ac;
    flag_word[ZF_POS] = zro;
    flag_word[SF_POS] = sgn;
    flag_word[OF_POS] = ov;
  end

endmodule

// File: rtl/afu_flag_reg.sv
module afu_flag_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R9

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q == $past(d))); // R9

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [2:0]        op_code,
  input  logic              word_mode,
  input  logic              wr_en,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  localparam int HI_W = DATA_W - BYTE_W;

  afu_ctl_t          ctl;
  logic              rst_sync_n;
  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic              load;
  logic [FLAG_W-1:0] flag_nxt;

  logic [BYTE_W-1:0] byte_res;
  logic              byte_cy, byte_ac, byte_ov;
  logic [DATA_W-1:0] word_res;
  logic              word_cy, word_ac, word_ov;
  logic              sel_cy, sel_ac, sel_ov;

  afu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  afu_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  always_comb begin
    b_eff = ctl.force_one ? DATA_W'(1) : op_b;
    cin   = ctl.use_cin & flags[CF_POS];
  end

  afu_lane #(.W(BYTE_W), .NIB_W(NIB_W)) u_byte_lane (
    .a   (op_a[BYTE_W-1:0]),
    .b   (b_eff[BYTE_W-1:0]),
    .sub (ctl.sub),
    .cin (cin),
    .res (byte_res),
    .cy  (byte_cy),
    .ac  (byte_ac),
    .ov  (byte_ov)
  );

  afu_lane #(.W(DATA_W), .NIB_W(NIB_W)) u_word_lane (
    .a   (op_a),
    .b   (b_eff),
    .sub (ctl.sub),
    .cin (cin),
    .res (word_res),
    .cy  (word_cy),
    .ac  (word_ac),
    .ov  (word_ov)
  );

  always_comb begin
    if (!ctl.valid) begin
      result = '0;
    end else if (word_mode) begin
      result = word_res;
    end else begin
      result = {{HI_W{1'b0}}, byte_res};
    end
    sel_cy = word_mode ? word_cy : byte_cy;
    sel_ac = word_mode ? word_ac : byte_ac;
    sel_ov = word_mode ? word_ov : byte_ov;
    load   = wr_en & ctl.valid;
  end

  afu_flag_pack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pack (
    .res       (result),
    .word_mode (word_mode),
    .cy        (sel_cy),
    .ac        (sel_ac),
    .ov        (sel_ov),
    .keep_cy   (ctl.keep_cy),
    .old_cy    (flags[CF_POS]),
    .flag_word (flag_nxt)
  );

  afu_flag_reg #(.W(FLAG_W)) u_freg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (load),
    .d     (flag_nxt),
    .q     (flags)
  );

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flags & ~FLAG_MASK) == '0); // R7

  AST_BYTE_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !word_mode |-> (result[DATA_W-1:BYTE_W] == '0)); // R8

  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (op_code == OP_INC || op_code == OP_DEC)) |=>
      (flags[CF_POS] == $past(flags[CF_POS]))); // R6

  AST_RSV_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (op_code == OP_RSV6 || op_code == OP_RSV7)) |=> $stable(flags)); // R11

  AST_ZERO_RESULT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && op_code <= OP_DEC && result == '0) |=> flags[ZF_POS]); // R5

endmodule

// File: tb/tb_arith_flag_unit.sv
module tb_arith_flag_unit;

  logic        clk;
  logic        rst_n;
  logic [15:0] op_a;
  logic [15:0] op_b;
  logic [2:0]  op_code;
  logic        word_mode;
  logic        wr_en;
  logic [15:0] result;
  logic [15:0] flags;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] exp_flags;

  arith_flag_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_code   (op_code),
    .word_mode (word_mode),
    .wr_en     (wr_en),
    .result    (result),
    .flags     (flags)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Arithmetic model: returns {flag word, result}
  function automatic logic [31:0] model(input int op, input int a, input int b,
                                        input bit wm, input logic [15:0] oldf);
    int w, mask, aa, bb, cc, full, sa, sb, ss, hb;
    bit cy, hf, ov, isub;
    logic [15:0] r, f;
    w    = wm ? 16 : 8;
    mask = (1 << w) - 1;
    aa   = a & mask;
    bb   = b & mask;
    cc   = 0;
    isub = 0;
    if (op > 5) return {oldf, 16'h0000};
    if (op == 1 || op == 3) cc = int'(oldf[0]);
    if (op == 2 || op == 3 || op == 5) isub = 1;
    if (op == 4 || op == 5) bb = 1;
    hb = 1 << (w - 1);
    sa = (aa >= hb) ? aa - (1 << w) : aa;
    sb = (bb >= hb) ? bb - (1 << w) : bb;
    if (!isub) begin
      full = aa + bb + cc;
      cy   = full > mask;
      hf   = ((aa & 15) + (bb & 15) + cc) > 15;
      ss   = sa + sb + cc;
    end else begin
      full = aa - bb - cc;
      cy   = full < 0;
      hf   = ((aa & 15) - (bb & 15) - cc) < 0;
      ss   = sa - sb - cc;
    end
    ov = (ss > hb - 1) || (ss < -hb);
    r  = 16'(full & mask);
    f  = 16'h0000;
    f[0]  = (op == 4 || op == 5) ? oldf[0] : cy;
    f[2]  = ($countones(r[7:0]) % 2) == 0;
    f[4]  = hf;
    f[6]  = (r == 16'h0000);
    f[7]  = r[w-1];
    f[11] = ov;
    return {f, r};
  endfunction

  task automatic step(input int op, input int a, input int b, input bit wm,
                      input bit we, input string req);
    logic [31:0] m;
    @(negedge clk);
    op_code   = 3'(op);
    op_a      = 16'(a);
    op_b      = 16'(b);
    word_mode = wm;
    wr_en     = we;
    m = model(op, a, b, wm, exp_flags);
    #1;
    chk(result == m[15:0], req, result, m[15:0]);
    @(posedge clk);
    #1;
    if (we) exp_flags = m[31:16];
    chk(flags == exp_flags, req, flags, exp_flags);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; op_code = '0; word_mode = 1'b0; wr_en = 1'b0;
    exp_flags = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(flags == 16'h0000, "R10 reset state", flags, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(flags == 16'h0000, "R10 after release", flags, 16'h0000);

    // Byte sweep: R1 R2 R3 R4 R5 R6 R7 R8, upper operand bits are garbage
    for (int op = 0; op < 6; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 16; k++) begin
          for (int c = 0; c < 2; c++) begin
            if (c == 1) step(0, 16'h00FF, 16'h0001, 1'b0, 1'b1, "R1 carry set");
            else        step(0, 16'h0000, 16'h0000, 1'b0, 1'b1, "R1 carry clear");
            step(op, ((a ^ 16'h5A) << 8) | a, (((k * 17) ^ 16'hC3) << 8) | (k * 17),
                 1'b0, 1'b1, "R1/R2/R3/R4/R5/R6/R7/R8 byte sweep");
          end
        end
      end
    end

    // Word-width corners
    step(0, 16'h0000, 16'h0000, 1'b1, 1'b1, "R5 word zero");
    step(2, 16'h0720, 16'h00E6, 1'b1, 1'b1, "R2 word sub");
    chk(result == 16'h063A, "R2 word sub literal result", result, 16'h063A);
    chk(flags == 16'h0014, "R4/R5 word sub literal flags", flags, 16'h0014);
    step(5, 16'h0000, 16'h1234, 1'b1, 1'b1, "R6 word dec of zero");
    chk(result == 16'hFFFF && flags[7] && !flags[6], "R6 dec literal", flags, 16'h0094);
    step(0, 16'hFFFF, 16'h0001, 1'b1, 1'b1, "R1 word wrap");
    step(4, 16'hFFFF, 16'h0000, 1'b1, 1'b1, "R6 inc keeps carry");
    step(1, 16'h7FFF, 16'h0000, 1'b1, 1'b1, "R1/R3 word adc overflow");
    step(0, 16'h8000, 16'h8000, 1'b1, 1'b1, "R3 word neg overflow");
    step(3, 16'h8000, 16'h0000, 1'b1, 1'b1, "R2/R3 word sbb");
    step(4, 16'h00FF, 16'h0000, 1'b1, 1'b1, "R4/R5 word inc low-byte parity");
    step(2, 16'h0000, 16'h0001, 1'b1, 1'b1, "R2 word borrow");
    step(5, 16'h8000, 16'h0000, 1'b1, 1'b1, "R3 word dec overflow");

    // Blocked writes: R9
    step(0, 16'h00FF, 16'h0001, 1'b0, 1'b0, "R9 held on add");
    step(2, 16'h1234, 16'h1234, 1'b1, 1'b0, "R9 held on sub");

    // Reserved codes: R11
    step(6, 16'h1234, 16'h4321, 1'b1, 1'b1, "R11 code 6");
    step(7, 16'h00FF, 16'h0001, 1'b0, 1'b1, "R11 code 7");

    // Mid-run reset: R10
    step(2, 16'h0000, 16'h0001, 1'b0, 1'b1, "R2 before reset");
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(flags == 16'h0000, "R10 async clear", flags, 16'h0000);
    exp_flags = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(flags == 16'h0000, "R10 held after release", flags, 16'h0000);
    step(0, 16'h0080, 16'h0080, 1'b0, 1'b1, "R1/R3 after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule